// File: doc/BRIEF.md
# Nonmaskable Interrupt Entry Sequencer

This block carries out the hardware side of taking a nonmaskable interrupt while the CPU runs with 24-bit addressing. A rising edge on the request line is latched and held until the core reaches an instruction boundary. The sequence then stores the return state on the long stack, one byte per memory cycle through a byte-wide write port that waits for an acknowledge. The return state is the three bytes of the program counter followed by a one-byte marker of value 03h, which records that the interrupt came from 24-bit mode; the mode stays in 24-bit addressing throughout.

After the last byte is accepted, the block presents the new program counter (the fixed vector 000066h), the decremented stack pointer and the updated interrupt-enable flags for one cycle. The old primary enable moves into the backup enable and the primary enable is cleared, so that a long-form return-from-NMI can restore the pre-interrupt state. A completion pulse follows one cycle later. While a nonmaskable request is latched or being served, the block withholds permission for a maskable interrupt.

Top module: `nmi_entry_seq`

## Requirements
- R1: A 0-to-1 transition of `nmi_req` latches one pending request; holding `nmi_req` high after that request has been served starts no further sequence.
- R2: A latched request starts the sequence only in a cycle where `insn_boundary` is 1; `irq_allow` equals `irq_pend` only while no request is latched and `busy` is 0, and is 0 otherwise.
- R3: The sequence writes four bytes with the stack pointer `spl_in` = S and program counter `pc_in` = P sampled at start: P[23:16] at S-1, P[15:8] at S-2, P[7:0] at S-3, then the marker 03h at S-4, with addresses wrapping modulo 2^24.
- R4: `mem_we` stays 1 with `mem_addr` and `mem_wdata` unchanged until a cycle with `mem_ack` = 1; each such cycle completes exactly one byte write.
- R5: In the cycle after the fourth write is acknowledged, `pc_load` is 1 for exactly one cycle with `pc_out` = 000066h and `spl_out` = S-4.
- R6: While `pc_load` is 1, `ief2_out` equals `ief1_in` as sampled at start and `ief1_out` is 0.
- R7: `done` is 1 for exactly one cycle, the cycle after `pc_load`.
- R8: After reset, `busy`, `mem_we`, `pc_load`, `done` are 0 and no request is latched (`irq_allow` follows `irq_pend`).
- R9: A new rising edge of `nmi_req` arriving while a sequence is running is held and served by a second sequence after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_req | input | 1 | Nonmaskable request, edge sensitive |
| insn_boundary | input | 1 | Core is between instructions |
| irq_pend | input | 1 | A maskable interrupt is pending |
| pc_in | input | 24 | Current program counter |
| spl_in | input | 24 | Current long stack pointer |
| ief1_in | input | 1 | Current primary interrupt enable |
| mem_ack | input | 1 | Memory accepted the current byte write |
| busy | output | 1 | Entry sequence in progress |
| irq_allow | output | 1 | Maskable interrupt may be taken |
| mem_we | output | 1 | Byte write strobe |
| mem_addr | output | 24 | Byte write address |
| mem_wdata | output | 8 | Byte write data |
| pc_load | output | 1 | Load new PC, SP and flags this cycle |
| pc_out | output | 24 | New program counter (vector) |
| spl_out | output | 24 | New long stack pointer |
| ief1_out | output | 1 | New primary interrupt enable |
| ief2_out | output | 1 | New backup interrupt enable |
| done | output | 1 | Entry sequence complete |

## Verification
An edge on the request is latched one cycle after it is seen, the first write strobe appears one cycle after a boundary cycle with a latched request, each following write appears in the cycle after the previous acknowledge, `pc_load` comes one cycle after the fourth acknowledge and `done` one cycle after that. The bench drives inputs and samples outputs on the falling edge, records each write on the cycle its acknowledge is driven, and notes the cycle numbers of `pc_load` and `done` so that their exact spacing is checked rather than merely their appearance. Acknowledge latencies of zero to three cycles and a stack pointer that wraps below zero shift these times, and the expected values follow them.

// File: rtl/nmi_seq_pkg.sv
package nmi_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_LOAD = 2'd2,
        ST_DONE = 2'd3
    } seq_state_e;

endpackage

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic take,
    output logic pending
);

    typedef struct packed {
        logic req_q;
        logic pend_q;
    } latch_t;

    latch_t r_q, r_d;
    logic   rise;

    always_comb begin
        r_d       = r_q;
        rise      = req & ~r_q.req_q;
        r_d.req_q = req;
        // a fresh edge wins over the clear caused by starting a sequence
        r_d.pend_q = (r_q.pend_q & ~take) | rise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pending = r_q.pend_q;

endmodule

// File: rtl/nmi_push_fsm.sv
module nmi_push_fsm
    import nmi_seq_pkg::*;
#(
    parameter int          AW     = 24,
    parameter int          DW     = 8,
    parameter logic [AW-1:0] VECTOR = 24'h000066,
    parameter logic [DW-1:0] MARKER = 8'h03
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pending,
    input  logic          insn_boundary,
    input  logic [AW-1:0] pc_in,
    input  logic [AW-1:0] spl_in,
    input  logic          ief1_in,
    input  logic          mem_ack,
    output logic          take,
    output logic          busy,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          pc_load,
    output logic [AW-1:0] pc_out,
    output logic [AW-1:0] spl_out,
    output logic          ief1_out,
    output logic          ief2_out,
    output logic          done
);

    localparam int NRA   = AW / DW;          // bytes of return address
    localparam int NPUSH = NRA + 1;          // plus the mode marker
    localparam int CW    = $clog2(NPUSH + 1);
    localparam logic [CW-1:0] LAST = CW'(NPUSH - 1);

    typedef struct packed {
        seq_state_e    state;
        logic [CW-1:0] cnt;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [AW-1:0] pc_sav;
        logic          ief1_sav;
        logic [AW-1:0] pc_new;
        logic [AW-1:0] sp_new;
        logic          ief1_new;
        logic          ief2_new;
    } seq_t;

    seq_t r_q, r_d;

    // Byte idx of the push order: return address most significant first, marker last
    function automatic logic [DW-1:0] push_byte(input logic [CW-1:0] idx,
                                                input logic [AW-1:0] pc);
        logic [DW-1:0] b;
        b = MARKER;
        for (int k = 0; k < NRA; k++) begin
            if (idx == CW'(k)) begin
                b = pc[AW-1-k*DW -: DW];
            end
        end
        return b;
    endfunction

    logic start;
    logic step;

    always_comb begin
        r_d   = r_q;
        start = (r_q.state == ST_IDLE) && pending && insn_boundary;
        step  = r_q.we && mem_ack;

        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state    = ST_PUSH;
                    r_d.cnt      = '0;
                    r_d.we       = 1'b1;
                    r_d.addr     = spl_in - AW'(1);
                    r_d.data     = push_byte('0, pc_in);
                    r_d.pc_sav   = pc_in;
                    r_d.ief1_sav = ief1_in;
                end
            end
            ST_PUSH: begin
                if (step) begin
                    if (r_q.cnt == LAST) begin
                        r_d.state    = ST_LOAD;
                        r_d.we       = 1'b0;
                        r_d.pc_new   = VECTOR;
                        r_d.sp_new   = r_q.addr;
                        r_d.ief2_new = r_q.ief1_sav;
                        r_d.ief1_new = 1'b0;
                    end else begin
                        r_d.cnt  = r_q.cnt + CW'(1);
                        r_d.addr = r_q.addr - AW'(1);
                        r_d.data = push_byte(r_q.cnt + CW'(1), r_q.pc_sav);
                    end
                end
            end
            ST_LOAD: begin
                r_d.state = ST_DONE;
            end
            ST_DONE: begin
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign take      = start;
    assign busy      = (r_q.state != ST_IDLE);
    assign mem_we    = r_q.we;
    assign mem_addr  = r_q.addr;
    assign mem_wdata = r_q.data;
    assign pc_load   = (r_q.state == ST_LOAD);
    assign done      = (r_q.state == ST_DONE);
    assign pc_out    = r_q.pc_new;
    assign spl_out   = r_q.sp_new;
    assign ief1_out  = r_q.ief1_new;
    assign ief2_out  = r_q.ief2_new;

endmodule

// File: rtl/nmi_entry_seq.sv
module nmi_entry_seq #(
    parameter int            AW     = 24,
    parameter int            DW     = 8,
    parameter logic [AW-1:0] VECTOR = 24'h000066,
    parameter logic [DW-1:0] MARKER = 8'h03
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nmi_req,
    input  logic          insn_boundary,
    input  logic          irq_pend,
    input  logic [AW-1:0] pc_in,
    input  logic [AW-1:0] spl_in,
    input  logic          ief1_in,
    input  logic          mem_ack,
    output logic          busy,
    output logic          irq_allow,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          pc_load,
    output logic [AW-1:0] pc_out,
    output logic [AW-1:0] spl_out,
    output logic          ief1_out,
    output logic          ief2_out,
    output logic          done
);

    logic pending;
    logic take;

    nmi_edge_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (nmi_req),
        .take    (take),
        .pending (pending)
    );

    nmi_push_fsm #(
        .AW     (AW),
        .DW     (DW),
        .VECTOR (VECTOR),
        .MARKER (MARKER)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .pending       (pending),
        .insn_boundary (insn_boundary),
        .pc_in         (pc_in),
        .spl_in        (spl_in),
        .ief1_in       (ief1_in),
        .mem_ack       (mem_ack),
        .take          (take),
        .busy          (busy),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .pc_load       (pc_load),
        .pc_out        (pc_out),
        .spl_out       (spl_out),
        .ief1_out      (ief1_out),
        .ief2_out      (ief2_out),
        .done          (done)
    );

    // nonmaskable work outranks any maskable request
    assign irq_allow = irq_pend & ~pending & ~busy;

endmodule

// File: rtl/nmi_entry_seq_chk.sv
module nmi_entry_seq_chk #(
    parameter int            AW     = 24,
    parameter int            DW     = 8,
    parameter logic [AW-1:0] VECTOR = 24'h000066
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq_allow,
    input logic          mem_we,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          pc_load,
    input logic [AW-1:0] pc_out,
    input logic          ief1_out,
    input logic          done
);

    a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_ack) |=> (mem_we && $stable(mem_addr) && $stable(mem_wdata)));

    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_ack) |=> (!mem_we || (mem_addr == $past(mem_addr) - AW'(1))));

    a_r5_vector: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> (pc_out == VECTOR));

    a_r5_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !pc_load);

    a_r6_ief1_clear: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> !ief1_out);

    a_r7_done_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> done);

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_no_irq_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
        irq_allow |-> !(mem_we || pc_load || done));

    a_r8_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, pc_load, done}));

endmodule

bind nmi_entry_seq nmi_entry_seq_chk #(
    .AW     (AW),
    .DW     (DW),
    .VECTOR (VECTOR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_allow (irq_allow),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .pc_load   (pc_load),
    .pc_out    (pc_out),
    .ief1_out  (ief1_out),
    .done      (done)
);

// File: tb/nmi_entry_seq_bench.sv
module nmi_entry_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_req = 1'b0;
    logic        insn_boundary = 1'b0;
    logic        irq_pend = 1'b0;
    logic [23:0] pc_in = '0;
    logic [23:0] spl_in = '0;
    logic        ief1_in = 1'b0;
    logic        mem_ack = 1'b0;
    logic        busy, irq_allow, mem_we, pc_load, ief1_out, ief2_out, done;
    logic [23:0] mem_addr, pc_out, spl_out;
    logic [7:0]  mem_wdata;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;   // 250 MHz

    nmi_entry_seq u_nmi_entry_seq (
        .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .insn_boundary(insn_boundary),
        .irq_pend(irq_pend), .pc_in(pc_in), .spl_in(spl_in), .ief1_in(ief1_in),
        .mem_ack(mem_ack), .busy(busy), .irq_allow(irq_allow), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .pc_load(pc_load),
        .pc_out(pc_out), .spl_out(spl_out), .ief1_out(ief1_out),
        .ief2_out(ief2_out), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [47:0] act,
                       input logic [47:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [23:0] pc;
        logic [23:0] sp;
        logic        ief1;
        logic [3:0]  dly;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{pc: 24'h123456, sp: 24'h00F000, ief1: 1'b1, dly: 4'd0},
        '{pc: 24'hABCDEF, sp: 24'h000002, ief1: 1'b1, dly: 4'd2},
        '{pc: 24'hFFFFFF, sp: 24'h800000, ief1: 1'b0, dly: 4'd3},
        '{pc: 24'h000000, sp: 24'hFFFFFF, ief1: 1'b1, dly: 4'd1}
    };

    // Serves one entry sequence: acknowledges writes after dly wait cycles and
    // checks the writes, the load cycle and the done spacing.
    task automatic serve(input logic [23:0] pc, input logic [23:0] sp, input logic ief1,
                         input int dly, input bit retrig);
        int nw = 0;
        int wc = 0;
        int ld = -1;
        int dn = -1;
        logic [23:0] a [4];
        logic [7:0]  d [4];
        logic [7:0]  eb;
        pc_in = pc; spl_in = sp; ief1_in = ief1; insn_boundary = 1'b1;
        for (int cyc = 0; cyc < 300 && dn < 0; cyc++) begin
            @(negedge clk);
            if (pc_load) begin
                ld = cyc;
                chk(pc_out == 24'h000066, "R5 pc_out", 48'(pc_out), 48'h66);
                chk(spl_out == sp - 24'd4, "R5 spl_out", 48'(spl_out), 48'(sp - 24'd4));
                chk(ief2_out == ief1, "R6 ief2_out", 48'(ief2_out), 48'(ief1));
                chk(ief1_out == 1'b0, "R6 ief1_out", 48'(ief1_out), 48'h0);
            end
            if (done) dn = cyc;
            if (retrig && cyc == 2) nmi_req = 1'b0;
            if (retrig && cyc == 3) nmi_req = 1'b1;
            mem_ack = 1'b0;
            if (mem_we) begin
                if (wc >= dly) begin
                    mem_ack = 1'b1;
                    if (nw < 4) begin a[nw] = mem_addr; d[nw] = mem_wdata; end
                    nw++;
                    wc = 0;
                end else begin
                    wc++;
                end
            end
        end
        mem_ack = 1'b0;
        chk(nw == 4, "R3 write count", 48'(nw), 48'd4);
        for (int k = 0; k < 4 && k < nw; k++) begin
            eb = (k == 3) ? 8'h03 : pc[23 - 8*k -: 8];
            chk(a[k] == sp - 24'(k + 1), "R3 write addr", 48'(a[k]), 48'(sp - 24'(k + 1)));
            chk(d[k] == eb, "R3 write data", 48'(d[k]), 48'(eb));
        end
        chk(ld >= 0, "R5 pc_load seen", 48'(ld), 48'd0);
        chk(dn == ld + 1, "R7 done one cycle after pc_load", 48'(dn), 48'(ld + 1));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : stim
        int seen;
        repeat (3) @(negedge clk);
        irq_pend = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk(!busy && !mem_we && !pc_load && !done, "R8 outputs idle in reset",
            48'({busy, mem_we, pc_load, done}), 48'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_we && !pc_load && !done, "R8 outputs idle after reset",
            48'({busy, mem_we, pc_load, done}), 48'h0);
        chk(irq_allow == 1'b1, "R8 no latched request", 48'(irq_allow), 48'h1);
        irq_pend = 1'b0;

        // table-driven sequences, R3 R4 R5 R6 R7
        foreach (VECS[i]) begin
            nmi_req = 1'b1;
            serve(VECS[i].pc, VECS[i].sp, VECS[i].ief1, int'(VECS[i].dly), 1'b0);
            nmi_req = 1'b0;
            repeat (2) @(negedge clk);
        end

        // R1: held level does not retrigger
        nmi_req = 1'b1;
        serve(24'h0A0B0C, 24'h001000, 1'b0, 0, 1'b0);
        seen = 0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (busy || mem_we) seen++;
        end
        chk(seen == 0, "R1 held level starts nothing", 48'(seen), 48'd0);
        nmi_req = 1'b0;
        @(negedge clk);

        // R2: no start without boundary, maskable blocked while latched
        insn_boundary = 1'b0;
        irq_pend = 1'b1;
        nmi_req = 1'b1;
        seen = 0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (busy || mem_we) seen++;
        end
        chk(seen == 0, "R2 waits for boundary", 48'(seen), 48'd0);
        chk(irq_allow == 1'b0, "R2 maskable held off by latched request", 48'(irq_allow), 48'h0);
        serve(24'h345678, 24'h002000, 1'b1, 1, 1'b0);
        @(negedge clk);
        chk(irq_allow == 1'b1, "R2 maskable allowed when idle", 48'(irq_allow), 48'h1);
        irq_pend = 1'b0;
        nmi_req = 1'b0;
        @(negedge clk);

        // R9: edge during a running sequence is served afterwards
        nmi_req = 1'b1;
        serve(24'h111111, 24'h003000, 1'b1, 2, 1'b1);
        serve(24'h222222, 24'h004000, 1'b0, 0, 1'b0);
        nmi_req = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy, "R9 idle after second sequence", 48'(busy), 48'h0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule